// File: doc/BRIEF.md
# ROM Patch Trap Comparator

This block sits beside a boot ROM and compares every qualified fetch on the ROM's code bus against a bank of programmable trap addresses. Each trap entry has its own arm bit. When a fetch address equals the address of an armed entry, the block sends a one-cycle bus-fault pulse to the processor. It also records a sticky error flag and the index of the matching entry, so the fault handler can branch to the replacement code for that entry.

Software reaches the block through a simple word-wide register write/read port. The port gives access to the trap addresses, the arm mask, the fault status word and a write-only clear word. The exception handler and the ROM itself are outside this block.

Top module: `rom_patch_trap`

## Requirements
- R1: After reset, every trap address, the arm mask and the status word read as zero, and `fault_o` is low.
- R2: Trap entry n is read and written at byte offset 4*n, for n = 0..29. The arm mask sits at offset 0x78 in bits 29:0, and bit n arms entry n. Bits 31:30 of the arm mask always read as zero. Offsets that are not decoded read as zero.
- R3: When `fetch_valid_i` is high with an address equal to an armed entry's address, `fault_o` is high during the following cycle only. Each such access produces exactly one cycle of `fault_o`.
- R4: A disarmed entry never produces a fault, even when its address equals the bus address. No fault is produced while `fetch_valid_i` is low.
- R5: The status word sits at offset 0x7C. A fault sets bit 0 (the error flag), and bits 5:1 hold the index of the entry that faulted. Both are visible in the same cycle that `fault_o` is high.
- R6: When several armed entries hold the same address, the lowest-numbered entry is reported.
- R7: The index is captured only when the error flag goes from clear to set. Later faults keep the first index until the flag is cleared.
- R8: Writing a word with bit 0 set to offset 0x80 clears the error flag and leaves the index bits unchanged. Writing a word with bit 0 clear has no effect. Writes to the status offset have no effect.
- R9: If a clear write and a faulting access happen in the same cycle, the fault wins: the error flag stays set and the new entry's index is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fetch_valid_i | input | 1 | Code-bus access qualifier |
| fetch_addr_i | input | 32 | Code-bus access address |
| fault_o | output | 1 | Bus-fault pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on reg_addr_i) |

## Verification
Two cases are hard to reach from the ports. The first is a clear write landing in the same cycle as a new trap hit. The second is a later hit on a different entry while the error flag is still set. The bench reaches both by timing: it places the clear write and the fetch strobe on the same clock edge, and it issues a second fetch to another armed entry before any clear, then reads the status back. A sweep arms all thirty entries with distinct computed addresses and fetches each one in turn, so every comparator and every index encoding is exercised. Duplicate addresses on entries 5 and 17, and a disarmed entry that still matches the bus address, cover priority and arming.

// File: rtl/rpt_pkg.sv
package rpt_pkg;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned STS_ERR_BIT = 0;
  localparam int unsigned STS_IDX_LSB = 1;

  function automatic int unsigned arm_ofs(int unsigned n_entries);
    return n_entries * 4;
  endfunction

  function automatic int unsigned sts_ofs(int unsigned n_entries);
    return n_entries * 4 + 4;
  endfunction

  function automatic int unsigned clr_ofs(int unsigned n_entries);
    return n_entries * 4 + 8;
  endfunction
endpackage

// File: rtl/rpt_regs.sv
module rpt_regs
  import rpt_pkg::*;
#(
  parameter int unsigned N      = 30,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned REG_AW = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_i,
  input  logic [REG_AW-1:0]          waddr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [N-1:0][ADDR_W-1:0]   trap_addr_o,
  output logic [N-1:0]               arm_o
);
  localparam logic [REG_AW-1:0] ARM_OFS = REG_AW'(arm_ofs(N));

  for (genvar i = 0; i < N; i++) begin : g_entry
    localparam logic [REG_AW-1:0] ENT_OFS = REG_AW'(i * 4);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          trap_addr_o[i] <= '0;
      else if (wr_i && waddr_i == ENT_OFS)  trap_addr_o[i] <= wdata_i[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          arm_o <= '0;
    else if (wr_i && waddr_i == ARM_OFS)  arm_o <= wdata_i[N-1:0];
  end
endmodule

// File: rtl/rpt_match.sv
module rpt_match #(
  parameter int unsigned N      = 30,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 5
) (
  input  logic                     valid_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [N-1:0][ADDR_W-1:0] trap_addr_i,
  input  logic [N-1:0]             arm_i,
  output logic                     hit_o,
  output logic [IDX_W-1:0]         idx_o
);
  logic [N-1:0] match;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match[i] = arm_i[i] && (trap_addr_i[i] == addr_i);
  end

  assign hit_o = valid_i && (|match);

  // lowest index wins: scan down so the last assignment is the smallest
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/rpt_status.sv
module rpt_status #(
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic [IDX_W-1:0] hit_idx_i,
  input  logic             clr_i,
  output logic             fault_o,
  output logic             err_o,
  output logic [IDX_W-1:0] idx_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_o <= 1'b0;
      err_o   <= 1'b0;
      idx_o   <= '0;
    end else begin
      fault_o <= hit_i;
      if (hit_i) begin
        err_o <= 1'b1;
        // a clear in the same cycle reopens capture
        if (!err_o || clr_i) idx_o <= hit_idx_i;
      end else if (clr_i) begin
        err_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rom_patch_trap.sv
module rom_patch_trap
  import rpt_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 30,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned REG_AW    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_valid_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  output logic              fault_o,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o
);
  localparam int unsigned IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;
  localparam logic [REG_AW-1:0] ARM_OFS = REG_AW'(arm_ofs(N_ENTRIES));
  localparam logic [REG_AW-1:0] STS_OFS = REG_AW'(sts_ofs(N_ENTRIES));
  localparam logic [REG_AW-1:0] CLR_OFS = REG_AW'(clr_ofs(N_ENTRIES));

  logic [N_ENTRIES-1:0][ADDR_W-1:0] trap_addr;
  logic [N_ENTRIES-1:0]             arm;
  logic                             hit;
  logic [IDX_W-1:0]                 hit_idx;
  logic                             sts_err;
  logic [IDX_W-1:0]                 sts_idx;
  logic                             clr_req;

  assign clr_req = reg_wr_i && (reg_addr_i == CLR_OFS) && reg_wdata_i[0];

  rpt_regs #(.N(N_ENTRIES), .ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (reg_wr_i),
    .waddr_i     (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .trap_addr_o (trap_addr),
    .arm_o       (arm)
  );

  rpt_match #(.N(N_ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_match (
    .valid_i     (fetch_valid_i),
    .addr_i      (fetch_addr_i),
    .trap_addr_i (trap_addr),
    .arm_i       (arm),
    .hit_o       (hit),
    .idx_o       (hit_idx)
  );

  rpt_status #(.IDX_W(IDX_W)) u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hit_i     (hit),
    .hit_idx_i (hit_idx),
    .clr_i     (clr_req),
    .fault_o   (fault_o),
    .err_o     (sts_err),
    .idx_o     (sts_idx)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ARM_OFS) begin
      reg_rdata_o[N_ENTRIES-1:0] = arm;
    end else if (reg_addr_i == STS_OFS) begin
      reg_rdata_o[STS_ERR_BIT]                   = sts_err;
      reg_rdata_o[STS_IDX_LSB +: IDX_W]          = sts_idx;
    end else begin
      for (int i = 0; i < N_ENTRIES; i++) begin
        if (reg_addr_i == REG_AW'(i * 4)) reg_rdata_o[ADDR_W-1:0] = trap_addr[i];
      end
    end
  end
endmodule

// File: rtl/rom_patch_trap_chk.sv
module rom_patch_trap_chk #(
  parameter int unsigned IDX_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fetch_valid_i,
  input logic             fault_o,
  input logic             hit_i,
  input logic             clr_i,
  input logic             err_i,
  input logic [IDX_W-1:0] idx_i
);
  // R4: a fault always traces back to a qualified access
  a_r4_fault_needs_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $past(fetch_valid_i));

  // R4: an idle bus cycle is followed by no fault
  a_r4_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_valid_i |=> !fault_o);

  // R5: the error flag is set whenever the fault pulse is out
  a_r5_fault_sets_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> err_i);

  // R7: the index holds while the flag is set and no clear arrives
  a_r7_idx_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i && !clr_i) |=> $stable(idx_i));

  // R8: a clear without a competing hit drops the flag
  a_r8_clear_drops_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !hit_i) |=> !err_i);
endmodule

bind rom_patch_trap rom_patch_trap_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .fetch_valid_i (fetch_valid_i),
  .fault_o       (fault_o),
  .hit_i         (hit),
  .clr_i         (clr_req),
  .err_i         (sts_err),
  .idx_i         (sts_idx)
);

// File: tb/rom_patch_trap_tb.sv
module rom_patch_trap_tb;
  localparam int N = 30;
  localparam logic [7:0] ARM = 8'h78, STS = 8'h7C, CLR = 8'h80;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fetch_valid_i = 1'b0;
  logic [31:0] fetch_addr_i = '0;
  logic        fault_o;
  logic        reg_wr_i = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;

  int n_chk = 0, n_fail = 0;
  logic [31:0] rd;

  always #10 clk_i = ~clk_i;

  rom_patch_trap u_dut (.*);

  function automatic logic [31:0] pat(int n);
    return 32'hA500_0000 ^ (32'(n) * 32'h0101_0104);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic rdr(logic [7:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  // one-cycle fetch; returns fault seen in the following cycle
  task automatic fetch(logic [31:0] a, output logic f);
    @(negedge clk_i);
    fetch_valid_i = 1'b1; fetch_addr_i = a;
    @(negedge clk_i);
    fetch_valid_i = 1'b0;
    f = fault_o;
  endtask

  initial begin
    #2_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic f;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: reset state
    for (int i = 0; i < N; i++) begin rdr(8'(i * 4), rd); check("R1", rd, 0); end
    rdr(ARM, rd); check("R1", rd, 0);
    rdr(STS, rd); check("R1", rd, 0);
    check("R1", {31'b0, fault_o}, 0);

    // R4: all-zero entries disarmed, fetch of address 0 does nothing
    fetch(32'h0, f); check("R4", {31'b0, f}, 0);

    // R2: program and read back all entries
    for (int i = 0; i < N; i++) wr(8'(i * 4), pat(i));
    for (int i = 0; i < N; i++) begin rdr(8'(i * 4), rd); check("R2", rd, pat(i)); end
    wr(ARM, 32'hFFFF_FFFF);
    rdr(ARM, rd); check("R2", rd, 32'h3FFF_FFFF);
    rdr(8'h90, rd); check("R2", rd, 0);
    rdr(CLR, rd); check("R2", rd, 0);

    // R3/R5: sweep every entry
    for (int i = 0; i < N; i++) begin
      fetch(pat(i), f); check("R3", {31'b0, f}, 1);
      rdr(STS, rd); check("R5", rd, {26'b0, 5'(i), 1'b1});
      @(negedge clk_i); check("R3", {31'b0, fault_o}, 0);
      wr(CLR, 32'h1);
      rdr(STS, rd); check("R8", rd, {26'b0, 5'(i), 1'b0});
    end

    // R4: non-matching address and idle bus
    fetch(32'h1234_5679, f); check("R4", {31'b0, f}, 0);
    @(negedge clk_i); fetch_addr_i = pat(3);
    @(negedge clk_i); check("R4", {31'b0, fault_o}, 0);

    // R4: disarmed entry 7 with matching bus address
    wr(ARM, 32'h3FFF_FF7F);
    fetch(pat(7), f); check("R4", {31'b0, f}, 0);
    rdr(STS, rd); check("R4", rd[0], 0);

    // R6: entries 5 and 17 share an address
    wr(8'(17 * 4), pat(5));
    fetch(pat(5), f); check("R6", {31'b0, f}, 1);
    rdr(STS, rd); check("R6", rd, {26'b0, 5'd5, 1'b1});

    // R7: later hit on entry 20 keeps index 5
    fetch(pat(20), f); check("R7", {31'b0, f}, 1);
    rdr(STS, rd); check("R7", rd, {26'b0, 5'd5, 1'b1});

    // R8: clear with bit 0 low and writes to status do nothing
    wr(CLR, 32'hFFFF_FFFE);
    rdr(STS, rd); check("R8", rd, {26'b0, 5'd5, 1'b1});
    wr(STS, 32'h0);
    rdr(STS, rd); check("R8", rd, {26'b0, 5'd5, 1'b1});

    // R9: clear and hit on entry 22 in the same cycle
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = CLR; reg_wdata_i = 32'h1;
    fetch_valid_i = 1'b1; fetch_addr_i = pat(22);
    @(negedge clk_i);
    reg_wr_i = 1'b0; fetch_valid_i = 1'b0;
    check("R9", {31'b0, fault_o}, 1);
    rdr(STS, rd); check("R9", rd, {26'b0, 5'd22, 1'b1});

    // R3: back-to-back accesses give one pulse each
    wr(CLR, 32'h1);
    @(negedge clk_i); fetch_valid_i = 1'b1; fetch_addr_i = pat(1);
    @(negedge clk_i); check("R3", {31'b0, fault_o}, 1); fetch_addr_i = pat(2);
    @(negedge clk_i); check("R3", {31'b0, fault_o}, 1); fetch_valid_i = 1'b0;
    @(negedge clk_i); check("R3", {31'b0, fault_o}, 0);
    rdr(STS, rd); check("R7", rd, {26'b0, 5'd1, 1'b1});

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule